// File: doc/BRIEF.md
# Instruction Class Decoder

This block takes one 32-bit fixed-length instruction word per cycle and turns it into a compact descriptor. The descriptor holds the condition code, an instruction class, the register indices the class uses, a flag-update bit, a destination-write bit, one 32-bit immediate (a rotated constant, a memory offset, a register list, a trap number or a sign-extended branch displacement), and indicators for control-flow change and trap. Execution, operand evaluation and condition testing belong to later stages.

The class is chosen from a 12-bit index. Its upper eight bits are word bits 27:20 and its lower four bits are word bits 7:4. The remaining fields are then read from fixed bit positions that depend on the class. Every output is registered. A word presented with `in_valid` high appears on the outputs one clock later. While `in_valid` is low, the last descriptor is held.

Top module: `icd_decoder`

## Requirements
- R1: Reset is synchronous and active high. It leaves `out_valid`=0, class 12 and every other output at 0. After any edge with `in_valid`=1, `out_valid` is 1 and the outputs describe the word taken at that edge. After an edge with `in_valid`=0, `out_valid` is 0 and all descriptor outputs keep their values.
- R2: `out_cond` equals bits 31:28 of the word.
- R3: The class codes are: 0 data processing, 1 multiply, 2 long multiply, 3 single load/store, 4 block transfer, 5 swap, 6 branch, 7 branch-and-link, 8 branch-exchange, 9 status read, 10 status write, 11 software interrupt, 12 illegal. Words with bits 27:25=000 are decoded in this priority order:
  - bits 7:4=1001 gives multiply when bits 24:22=000, long multiply when bits 24:23=01, and swap when bits 24:23=10 with bits 21:20=00.
  - otherwise, bit 7 and bit 4 both set gives load/store.
  - otherwise, bits 24:23=10 with bit 20=0 gives one of: branch-exchange (bits 7:4=0001, bits 22:21=01), status read (bits 7:4=0000, bit 21=0) or status write (bits 7:4=0000, bit 21=1).
  - anything else gives data processing.
- R4: Data processing: rn=bits 19:16. Compare/test operations (bits 24:23=10) set `out_setf`=1, `out_wr`=0 and rd=0. Other operations give rd=bits 15:12, `out_wr`=1 and `out_setf`=bit 20. With bit 25 set, `out_imm` is bits 7:0 rotated right by twice bits 11:8, and rm=rs=0. Otherwise rm=bits 3:0, and rs=bits 11:8 when bit 4 is set, else rs=0.
- R5: Multiply: rd=bits 19:16, rm=bits 3:0, rs=bits 11:8, and rn=bits 15:12 only when bit 21 (accumulate) is set, else 0. Long multiply: rd=bits 15:12 (low half), rn=bits 19:16 (high half), rm=bits 3:0, rs=bits 11:8. Both classes set `out_wr`=1 and `out_setf`=bit 20.
- R6: `out_branch` is set in these cases:
  - data-processing, multiply or long-multiply words that write rd=15.
  - every branch, branch-and-link and branch-exchange word (branch-exchange gives rm=bits 3:0).
  - block transfers whose register list has bit 15 set.
- R7: For branch and branch-and-link, `out_imm` is bits 23:0, sign-extended and multiplied by 4.
- R8: Software interrupt (bits 27:24=1111) gives `out_imm`=bits 23:0 zero-extended and `out_trap`=1. No other class sets `out_trap`.
- R9: Coprocessor encodings (bits 27:25=110, or 111 with bit 24=0), bits 27:25=011 with bit 4 set, and every other index with no class decode as illegal. For these, every field and indicator is 0.
- R10: Load/store: rd=bits 15:12, rn=bits 19:16, `out_wr`=bit 20. Word/byte forms (bits 27:26=01) give `out_imm`=bits 11:0 when bit 25=0, else rm=bits 3:0. Halfword forms give `out_imm`={bits 11:8, bits 3:0} when bit 22=1, else rm=bits 3:0.
- R11: Block transfer gives rn=bits 19:16, `out_imm`=bits 15:0 and `out_wr`=bit 20. Swap gives rd=bits 15:12, rn=bits 19:16, rm=bits 3:0 and `out_wr`=1. Status read gives rd=bits 15:12 and `out_wr`=1. Status write gives `out_setf`=NOT bit 22, and either `out_imm` (rotated as in R4) when bit 25=1 or rm=bits 3:0. Any field not named for a class is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on in_word is to be decoded |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Descriptor was loaded on the last edge |
| out_cond | output | 4 | Condition code |
| out_cls | output | 4 | Instruction class code |
| out_rd | output | 4 | Destination / low destination register |
| out_rn | output | 4 | Base, first operand, high destination or accumulate register |
| out_rm | output | 4 | Second operand / target register |
| out_rs | output | 4 | Shift-amount or multiplier register |
| out_setf | output | 1 | Flags are updated |
| out_wr | output | 1 | A destination register is written |
| out_branch | output | 1 | Instruction may change the program counter |
| out_trap | output | 1 | Instruction traps |
| out_imm | output | 32 | Immediate, offset, register list or displacement |

## Verification
The properties assume that `in_word` is stable and free of unknown bits at every edge where `in_valid` is high. They also assume that reset is held for at least one edge before the first word. The bench drives both inputs only on falling edges from fully specified 32-bit values, and it holds reset over several edges at the start. Random words are skewed toward the 1001 pattern in bits 7:4 so that the multiply and swap space is reached. `in_valid` is dropped on about one cycle in eight so that the hold behaviour is exercised.

// File: rtl/icd_pkg.sv
`timescale 1ns/1ps
package icd_pkg;
  localparam int ICD_WORD_W = 32;
  localparam int ICD_REG_W  = 4;
  localparam int ICD_CLS_W  = 4;
  localparam int ICD_HI_LSB = 20;
  localparam int ICD_HI_W   = 8;
  localparam int ICD_LO_LSB = 4;
  localparam int ICD_LO_W   = 4;
  localparam int ICD_IDX_W  = ICD_HI_W + ICD_LO_W;
  localparam int ICD_OFS_W  = 24;

  typedef enum logic [ICD_CLS_W-1:0] {
    CLS_DP     = 4'd0,
    CLS_MUL    = 4'd1,
    CLS_MULL   = 4'd2,
    CLS_LDST   = 4'd3,
    CLS_BLOCK  = 4'd4,
    CLS_SWAP   = 4'd5,
    CLS_BR     = 4'd6,
    CLS_BRL    = 4'd7,
    CLS_BX     = 4'd8,
    CLS_PSR_RD = 4'd9,
    CLS_PSR_WR = 4'd10,
    CLS_SWI    = 4'd11,
    CLS_ILL    = 4'd12
  } icd_cls_e;

  typedef struct packed {
    icd_cls_e              cls;
    logic [ICD_REG_W-1:0]  rd;
    logic [ICD_REG_W-1:0]  rn;
    logic [ICD_REG_W-1:0]  rm;
    logic [ICD_REG_W-1:0]  rs;
    logic                  setf;
    logic                  wr;
    logic                  br;
    logic                  trap;
    logic [ICD_WORD_W-1:0] imm;
  } icd_desc_t;

  localparam icd_desc_t ICD_DESC_RST = '{
    cls: CLS_ILL, rd: '0, rn: '0, rm: '0, rs: '0,
    setf: 1'b0, wr: 1'b0, br: 1'b0, trap: 1'b0, imm: '0
  };
endpackage

// File: rtl/icd_class_lut.sv
`timescale 1ns/1ps
module icd_class_lut
  import icd_pkg::*;
(
  input  logic [ICD_IDX_W-1:0] idx,
  output icd_cls_e             cls
);
  logic [ICD_HI_W-1:0] hi;
  logic [ICD_LO_W-1:0] lo;
  logic                misc_space;

  assign hi = idx[ICD_IDX_W-1:ICD_LO_W];
  assign lo = idx[ICD_LO_W-1:0];
  // compare/test opcodes without flag update are reused for other functions
  assign misc_space = (hi[4:3] == 2'b10) && !hi[0];

  always_comb begin
    cls = CLS_ILL;
    unique case (hi[7:5])
      3'b000: begin
        if (lo == 4'b1001) begin
          if (hi[4:2] == 3'b000)                         cls = CLS_MUL;
          else if (hi[4:3] == 2'b01)                     cls = CLS_MULL;
          else if (hi[4:3] == 2'b10 && hi[1:0] == 2'b00) cls = CLS_SWAP;
          else                                           cls = CLS_ILL;
        end else if (lo[3] && lo[0]) begin
          cls = CLS_LDST;
        end else if (misc_space) begin
          if (lo == 4'b0001 && hi[2:1] == 2'b01) cls = CLS_BX;
          else if (lo == 4'b0000)                cls = hi[1] ? CLS_PSR_WR : CLS_PSR_RD;
          else                                   cls = CLS_ILL;
        end else begin
          cls = CLS_DP;
        end
      end
      3'b001:  cls = misc_space ? (hi[1] ? CLS_PSR_WR : CLS_ILL) : CLS_DP;
      3'b010:  cls = CLS_LDST;
      3'b011:  cls = lo[0] ? CLS_ILL : CLS_LDST;
      3'b100:  cls = CLS_BLOCK;
      3'b101:  cls = hi[4] ? CLS_BRL : CLS_BR;
      3'b110:  cls = CLS_ILL;
      default: cls = hi[4] ? CLS_SWI : CLS_ILL;
    endcase
  end
endmodule

// File: rtl/icd_rot_imm.sv
`timescale 1ns/1ps
module icd_rot_imm #(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W+ROT_W-1:0] field,
  output logic [WORD_W-1:0]      value
);
  localparam int FIELD_W = IMM_W + ROT_W;

  logic [WORD_W-1:0]   base;
  logic [2*WORD_W-1:0] dbl;

  assign base  = WORD_W'(field[IMM_W-1:0]);
  // rotate right by twice the rotate field: shift a doubled copy
  assign dbl   = {base, base} >> {field[FIELD_W-1:IMM_W], 1'b0};
  assign value = dbl[WORD_W-1:0];
endmodule

// File: rtl/icd_fields.sv
`timescale 1ns/1ps
module icd_fields
  import icd_pkg::*;
(
  input  logic [ICD_WORD_W-1:0] word,
  input  icd_cls_e              cls,
  output icd_desc_t             desc
);
  localparam int SEXT_W = ICD_WORD_W - ICD_OFS_W - 2;

  logic [ICD_WORD_W-1:0] rot_val;
  logic [ICD_REG_W-1:0]  f_19_16, f_15_12, f_11_8, f_3_0;
  logic                  is_cmp;

  icd_rot_imm #(.WORD_W(ICD_WORD_W), .IMM_W(8), .ROT_W(4)) u_rot (
    .field (word[11:0]),
    .value (rot_val)
  );

  assign f_19_16 = word[19:16];
  assign f_15_12 = word[15:12];
  assign f_11_8  = word[11:8];
  assign f_3_0   = word[3:0];
  assign is_cmp  = (word[24:23] == 2'b10);

  always_comb begin
    desc     = '0;
    desc.cls = cls;
    unique case (cls)
      CLS_DP: begin
        desc.rn   = f_19_16;
        desc.wr   = !is_cmp;
        desc.setf = is_cmp ? 1'b1 : word[20];
        desc.rd   = is_cmp ? '0 : f_15_12;
        if (word[25]) begin
          desc.imm = rot_val;
        end else begin
          desc.rm = f_3_0;
          desc.rs = word[4] ? f_11_8 : '0;
        end
        desc.br = !is_cmp && (f_15_12 == '1);
      end
      CLS_MUL: begin
        desc.rd   = f_19_16;
        desc.rn   = word[21] ? f_15_12 : '0;
        desc.rm   = f_3_0;
        desc.rs   = f_11_8;
        desc.setf = word[20];
        desc.wr   = 1'b1;
        desc.br   = (f_19_16 == '1);
      end
      CLS_MULL: begin
        desc.rd   = f_15_12;
        desc.rn   = f_19_16;
        desc.rm   = f_3_0;
        desc.rs   = f_11_8;
        desc.setf = word[20];
        desc.wr   = 1'b1;
        desc.br   = (f_15_12 == '1);
      end
      CLS_LDST: begin
        desc.rd = f_15_12;
        desc.rn = f_19_16;
        desc.wr = word[20];
        if (word[27:26] == 2'b01) begin
          if (word[25]) desc.rm  = f_3_0;
          else          desc.imm = ICD_WORD_W'(word[11:0]);
        end else begin
          if (word[22]) desc.imm = ICD_WORD_W'({f_11_8, f_3_0});
          else          desc.rm  = f_3_0;
        end
      end
      CLS_BLOCK: begin
        desc.rn  = f_19_16;
        desc.imm = ICD_WORD_W'(word[15:0]);
        desc.wr  = word[20];
        desc.br  = word[15];
      end
      CLS_SWAP: begin
        desc.rd = f_15_12;
        desc.rn = f_19_16;
        desc.rm = f_3_0;
        desc.wr = 1'b1;
      end
      CLS_BR, CLS_BRL: begin
        desc.imm = {{SEXT_W{word[ICD_OFS_W-1]}}, word[ICD_OFS_W-1:0], 2'b00};
        desc.br  = 1'b1;
      end
      CLS_BX: begin
        desc.rm = f_3_0;
        desc.br = 1'b1;
      end
      CLS_PSR_RD: begin
        desc.rd = f_15_12;
        desc.wr = 1'b1;
      end
      CLS_PSR_WR: begin
        desc.setf = !word[22];
        if (word[25]) desc.imm = rot_val;
        else          desc.rm  = f_3_0;
      end
      CLS_SWI: begin
        desc.imm  = ICD_WORD_W'(word[ICD_OFS_W-1:0]);
        desc.trap = 1'b1;
      end
      default: begin
        desc     = '0;
        desc.cls = CLS_ILL;
      end
    endcase
  end
endmodule

// File: rtl/icd_decoder.sv
`timescale 1ns/1ps
module icd_decoder
  import icd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [ICD_WORD_W-1:0] in_word,
  output logic                  out_valid,
  output logic [3:0]            out_cond,
  output logic [ICD_CLS_W-1:0]  out_cls,
  output logic [ICD_REG_W-1:0]  out_rd,
  output logic [ICD_REG_W-1:0]  out_rn,
  output logic [ICD_REG_W-1:0]  out_rm,
  output logic [ICD_REG_W-1:0]  out_rs,
  output logic                  out_setf,
  output logic                  out_wr,
  output logic                  out_branch,
  output logic                  out_trap,
  output logic [ICD_WORD_W-1:0] out_imm
);
  logic [ICD_IDX_W-1:0] idx;
  icd_cls_e             cls_c;
  icd_desc_t            desc_c;
  icd_desc_t            desc_q;
  logic [3:0]           cond_q;
  logic                 valid_q;

  assign idx = {in_word[ICD_HI_LSB +: ICD_HI_W], in_word[ICD_LO_LSB +: ICD_LO_W]};

  icd_class_lut u_lut (
    .idx (idx),
    .cls (cls_c)
  );

  icd_fields u_fields (
    .word (in_word),
    .cls  (cls_c),
    .desc (desc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cond_q  <= '0;
      desc_q  <= ICD_DESC_RST;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        cond_q <= in_word[ICD_WORD_W-1 -: 4];
        desc_q <= desc_c;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_cond   = cond_q;
  assign out_cls    = desc_q.cls;
  assign out_rd     = desc_q.rd;
  assign out_rn     = desc_q.rn;
  assign out_rm     = desc_q.rm;
  assign out_rs     = desc_q.rs;
  assign out_setf   = desc_q.setf;
  assign out_wr     = desc_q.wr;
  assign out_branch = desc_q.br;
  assign out_trap   = desc_q.trap;
  assign out_imm    = desc_q.imm;
endmodule

// File: rtl/icd_decoder_chk.sv
`timescale 1ns/1ps
module icd_decoder_chk
  import icd_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [ICD_WORD_W-1:0] in_word,
  input logic                  out_valid,
  input logic [3:0]            out_cond,
  input logic [ICD_CLS_W-1:0]  out_cls,
  input logic                  out_setf,
  input logic                  out_wr,
  input logic                  out_branch,
  input logic                  out_trap,
  input logic [ICD_WORD_W-1:0] out_imm
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_cls) && $stable(out_imm) && $stable(out_cond)));

  // R2
  cond_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_cond == $past(in_word[ICD_WORD_W-1 -: 4])));

  // R8
  trap_only_swi_chk: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> (out_cls == CLS_SWI));

  // R6
  flow_class_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (out_cls == CLS_BR || out_cls == CLS_BRL || out_cls == CLS_BX) |-> out_branch);

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_cls == CLS_ILL) |-> (!out_wr && !out_setf && !out_branch && !out_trap && out_imm == '0));

  // R4
  compare_sets_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cls == CLS_DP && !out_wr) |-> out_setf);
endmodule

bind icd_decoder icd_decoder_chk u_icd_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_word    (in_word),
  .out_valid  (out_valid),
  .out_cond   (out_cond),
  .out_cls    (out_cls),
  .out_setf   (out_setf),
  .out_wr     (out_wr),
  .out_branch (out_branch),
  .out_trap   (out_trap),
  .out_imm    (out_imm)
);

// File: tb/icd_decoder_bench.sv
`timescale 1ns/1ps
module icd_decoder_bench;
  import icd_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [3:0]  out_cond;
  logic [3:0]  out_cls;
  logic [3:0]  out_rd, out_rn, out_rm, out_rs;
  logic        out_setf, out_wr, out_branch, out_trap;
  logic [31:0] out_imm;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  icd_desc_t exp_d;
  logic [3:0] exp_cond;
  logic       exp_valid;

  always #4 clk = ~clk;

  icd_decoder u_icd_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_cond(out_cond), .out_cls(out_cls),
    .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm), .out_rs(out_rs),
    .out_setf(out_setf), .out_wr(out_wr), .out_branch(out_branch),
    .out_trap(out_trap), .out_imm(out_imm)
  );

  function automatic logic [31:0] rotr(input logic [7:0] v, input logic [3:0] r);
    logic [31:0] b;
    int          a;
    b = {24'h0, v};
    a = 2 * int'(r);
    if (a == 0) return b;
    return (b >> a) | (b << (32 - a));
  endfunction

  function automatic icd_desc_t model(input logic [31:0] w);
    icd_desc_t e;
    e = '0;
    e.cls = CLS_ILL;
    if (w[27:25] == 3'b000 && w[7:4] == 4'b1001) begin
      if (w[24:22] == 3'b000) begin
        e.cls = CLS_MUL; e.rd = w[19:16]; e.rn = w[21] ? w[15:12] : 4'h0;
        e.rm = w[3:0]; e.rs = w[11:8]; e.setf = w[20]; e.wr = 1; e.br = (w[19:16] == 4'hF);
      end else if (w[24:23] == 2'b01) begin
        e.cls = CLS_MULL; e.rd = w[15:12]; e.rn = w[19:16];
        e.rm = w[3:0]; e.rs = w[11:8]; e.setf = w[20]; e.wr = 1; e.br = (w[15:12] == 4'hF);
      end else if (w[24:23] == 2'b10 && w[21:20] == 2'b00) begin
        e.cls = CLS_SWAP; e.rd = w[15:12]; e.rn = w[19:16]; e.rm = w[3:0]; e.wr = 1;
      end
    end else if (w[27:25] == 3'b000 && w[7] && w[4]) begin
      e.cls = CLS_LDST; e.rd = w[15:12]; e.rn = w[19:16]; e.wr = w[20];
      if (w[22]) e.imm = {24'h0, w[11:8], w[3:0]}; else e.rm = w[3:0];
    end else if (w[27:26] == 2'b00 && w[24:23] == 2'b10 && !w[20]) begin
      if (!w[25]) begin
        if (w[7:4] == 4'b0001 && w[22:21] == 2'b01) begin
          e.cls = CLS_BX; e.rm = w[3:0]; e.br = 1;
        end else if (w[7:4] == 4'b0000 && !w[21]) begin
          e.cls = CLS_PSR_RD; e.rd = w[15:12]; e.wr = 1;
        end else if (w[7:4] == 4'b0000) begin
          e.cls = CLS_PSR_WR; e.rm = w[3:0]; e.setf = !w[22];
        end
      end else if (w[21]) begin
        e.cls = CLS_PSR_WR; e.imm = rotr(w[7:0], w[11:8]); e.setf = !w[22];
      end
    end else if (w[27:26] == 2'b00) begin
      e.cls = CLS_DP; e.rn = w[19:16];
      if (w[24:23] == 2'b10) begin e.setf = 1; e.wr = 0; end
      else begin e.setf = w[20]; e.wr = 1; e.rd = w[15:12]; end
      if (w[25]) e.imm = rotr(w[7:0], w[11:8]);
      else begin e.rm = w[3:0]; if (w[4]) e.rs = w[11:8]; end
      e.br = e.wr && (w[15:12] == 4'hF);
    end else if (w[27:26] == 2'b01) begin
      if (!(w[25] && w[4])) begin
        e.cls = CLS_LDST; e.rd = w[15:12]; e.rn = w[19:16]; e.wr = w[20];
        if (w[25]) e.rm = w[3:0]; else e.imm = {20'h0, w[11:0]};
      end
    end else if (w[27:25] == 3'b100) begin
      e.cls = CLS_BLOCK; e.rn = w[19:16]; e.imm = {16'h0, w[15:0]}; e.wr = w[20]; e.br = w[15];
    end else if (w[27:25] == 3'b101) begin
      e.cls = w[24] ? CLS_BRL : CLS_BR; e.br = 1;
      e.imm = {{6{w[23]}}, w[23:0], 2'b00};
    end else if (w[27:24] == 4'b1111) begin
      e.cls = CLS_SWI; e.imm = {8'h0, w[23:0]}; e.trap = 1;
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0:             return "R4";
      4'd1, 4'd2:       return "R5";
      4'd3:             return "R10";
      4'd6, 4'd7:       return "R7";
      4'd8:             return "R6";
      4'd11:            return "R8";
      4'd12:            return "R9";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic compare_all();
    logic [55:0] act;
    act = {out_cls, out_rd, out_rn, out_rm, out_rs, out_setf, out_wr, out_branch, out_trap, out_imm};
    check(out_valid == exp_valid, "R1", 64'(out_valid), 64'(exp_valid));
    check(out_cond == exp_cond, "R2", 64'(out_cond), 64'(exp_cond));
    check(act == 56'(exp_d), tag_of(exp_d.cls), 64'(act), 64'(56'(exp_d)));
  endtask

  task automatic apply(input bit v, input logic [31:0] w);
    in_valid = v;
    in_word  = w;
    @(posedge clk);
    @(negedge clk);
    exp_valid = v;
    if (v) begin
      exp_d    = model(w);
      exp_cond = w[31:28];
    end
    compare_all();
  endtask

  task automatic directed(input logic [31:0] w, input logic [3:0] cls_exp, input string tag);
    apply(1'b1, w);
    check(out_cls == cls_exp, tag, 64'(out_cls), 64'(cls_exp));
  endtask

  initial begin
    void'($urandom(32'h1CD5));
    rst = 1'b1; in_valid = 1'b1; in_word = 32'hEF00_0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0 && out_cls == 4'd12 && out_imm == 32'h0 && out_cond == 4'h0 && !out_trap,
          "R1", {out_valid, out_cls, out_imm}, {1'b0, 4'd12, 32'h0});
    rst = 1'b0; in_valid = 1'b0;
    exp_valid = 1'b0; exp_cond = 4'h0; exp_d = ICD_DESC_RST;

    // R4 data processing: write to r15 flags a branch (R6)
    directed(32'hE081_F002, 4'd0, "R4");
    check(out_branch == 1'b1, "R6", 64'(out_branch), 64'd1);
    // R4 compare: no destination, flags set
    directed(32'hE153_0004, 4'd0, "R4");
    // R4 rotated immediate
    directed(32'hE3A0_14FF, 4'd0, "R4");
    check(out_imm == 32'hFF00_0000, "R4", 64'(out_imm), 64'hFF00_0000);
    // R5 multiply to r15, multiply-accumulate, long multiply
    directed(32'hE00F_0291, 4'd1, "R5");
    directed(32'hE021_3192, 4'd1, "R5");
    directed(32'hE085_4392, 4'd2, "R5");
    // R11 swap, status read/write, block transfer
    directed(32'hE101_2093, 4'd5, "R11");
    directed(32'hE10F_0000, 4'd9, "R11");
    directed(32'hE129_F000, 4'd10, "R11");
    directed(32'hE328_F20F, 4'd10, "R11");
    check(out_imm == 32'hF000_0000, "R11", 64'(out_imm), 64'hF000_0000);
    directed(32'hE8BD_8010, 4'd4, "R11");
    // R6 branch-exchange
    directed(32'hE12F_FF1E, 4'd8, "R6");
    // R7 negative and positive displacements
    directed(32'hEAFF_FFFE, 4'd6, "R7");
    check(out_imm == 32'hFFFF_FFF8, "R7", 64'(out_imm), 64'hFFFF_FFF8);
    directed(32'hEB00_0010, 4'd7, "R7");
    check(out_imm == 32'h0000_0040, "R7", 64'(out_imm), 64'h40);
    // R8 software interrupt
    directed(32'hEF12_3456, 4'd11, "R8");
    check(out_trap == 1'b1 && out_imm == 32'h0012_3456, "R8", {out_trap, out_imm}, {1'b1, 32'h0012_3456});
    // R9 coprocessor, undefined, unassigned misc
    directed(32'hEE00_0010, 4'd12, "R9");
    directed(32'hED00_0000, 4'd12, "R9");
    directed(32'hE7F0_00F0, 4'd12, "R9");
    directed(32'hE160_0070, 4'd12, "R9");
    // R10 load/store forms
    directed(32'hE59F_1004, 4'd3, "R10");
    directed(32'hE1D0_10B2, 4'd3, "R10");
    directed(32'hE191_00B2, 4'd3, "R10");
    // R3 class index mapping, R2 condition field
    directed(32'h1000_0000, 4'd0, "R3");
    // R1 hold while idle: a different word must not reach the outputs
    apply(1'b0, 32'hEF00_0000);
    check(out_cls == 4'd0 && out_cond == 4'h1, "R1", {out_cls, out_cond}, {4'd0, 4'h1});

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      bit          v;
      w = $urandom;
      if ($urandom % 4 == 0) w[7:4] = 4'b1001;
      v = ($urandom % 8) != 0;
      apply(v, w);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule